// File: doc/BRIEF.md
# USB Host Operational Status and Command Registers

This block holds the operational command word and the 32-bit status word of a USB 2.0 host controller. Software reaches both through a simple register port. A write takes effect at the clock edge. A read returns the addressed word combinationally. The command word sits at offset 0x20 and the status word at offset 0x24. The command word carries run/stop, the two schedule enables and the async-advance doorbell. Those bits also drive the schedule engine directly.

The status word gives the engine's real view of the controller. The schedule-on bits change only when the engine acknowledges a start or stop. The halted flag follows the engine's stop acknowledgement, not the run bit. The reclamation flag reports whether the asynchronous list is empty. The async-advance interrupt flag is a sticky bit. A doorbell arms it, the next schedule advance sets it, and software clears it by writing one to it. An internal error from the engine drops run/stop without any software action.

Top module: `usbh_opreg_stat`

## Requirements
- R1: After synchronous reset the status word reads 0x00001000 (only halted, bit 12, set) and the command word reads 0.
- R2: A write to offset 0x20 loads run/stop from bit 0, periodic enable from bit 4 and async enable from bit 5. All other command bits read 0, except the doorbell (bit 6) as R7 describes.
- R3: Status bit 15 (async on) and bit 14 (periodic on) reset to 0. Each takes the value of its enable bit only at an edge where the engine's matching acknowledge strobe is high, and holds otherwise.
- R4: The halted flag (status bit 12) clears at the same edge where run/stop becomes 1, so it never reads 1 while run/stop reads 1.
- R5: With run/stop at 0, the halted flag is set at the edge where the engine-stopped input is high, so it reads 1 one cycle later. Engine-stopped has no effect while run/stop stays 1.
- R6: An internal-error strobe forces run/stop to 0 at that edge, even against a simultaneous software write of 1.
- R7: Writing 1 to command bit 6 arms the doorbell, which then reads back as 1. Writing 0 to bit 6 leaves a pending doorbell unchanged.
- R8: A schedule-advance strobe while the doorbell is pending sets status bit 5 and clears the doorbell at the same edge. An advance with no doorbell pending changes neither.
- R9: Status bit 5 clears when software writes 1 to it at offset 0x24. Writing 0 leaves it unchanged, and writes to the read-only status bits change nothing.
- R10: When an advance with a pending doorbell and a write-one-to-clear of bit 5 meet at the same edge, bit 5 ends up 1.
- R11: Status bit 13 (reclamation) shows the async-list-empty input as sampled at the previous edge.
- R12: Status bits 31:16, 11:6 and 4:0 read 0, and a read of any offset other than 0x20 or 0x24 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W (8) | Register offset for read and write |
| reg_wen | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| eng_advance | input | 1 | Engine advanced the asynchronous schedule |
| eng_stopped | input | 1 | Engine has stopped executing |
| eng_int_err | input | 1 | Engine internal error |
| eng_async_ack | input | 1 | Engine applied the async enable |
| eng_periodic_ack | input | 1 | Engine applied the periodic enable |
| eng_async_empty | input | 1 | Asynchronous list is empty |
| cmd_run | output | 1 | Run/stop bit to the engine |
| cmd_async_en | output | 1 | Async schedule enable to the engine |
| cmd_periodic_en | output | 1 | Periodic schedule enable to the engine |
| cmd_doorbell | output | 1 | Async-advance doorbell pending |

## Verification
The assertions assume that every engine input is a clean, synchronous level sampled at the rising edge. They place no ordering on those inputs. An acknowledge, a stop or an error may arrive in any cycle, whether or not the command bits call for it. They also assume that any offset may be written. The stimulus therefore draws engine strobes independently of the command state and mixes writes to both registers and to an unused offset with fully random data. A few directed sequences then force the simultaneous-event cases of R6 and R10.

// File: rtl/usbh_opreg_pkg.sv
package usbh_opreg_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 8;

    // Register offsets from the operational base
    localparam logic [ADDR_W-1:0] CMD_OFS = 8'h20;
    localparam logic [ADDR_W-1:0] STS_OFS = 8'h24;

    // Command word bit positions
    localparam int C_RUN = 0;
    localparam int C_PER = 4;
    localparam int C_ASY = 5;
    localparam int C_DB  = 6;

    // Status word bit positions
    localparam int S_IAA = 5;
    localparam int S_HLT = 12;
    localparam int S_RCL = 13;
    localparam int S_PER = 14;
    localparam int S_ASY = 15;

    typedef struct packed {
        logic run;
        logic per_en;
        logic asy_en;
        logic doorbell;
    } cmd_t;

    typedef struct packed {
        logic asy_on;
        logic per_on;
        logic reclaim;
        logic halted;
        logic iaa;
    } sts_t;

    typedef enum logic [1:0] {SEL_NONE, SEL_CMD, SEL_STS} sel_e;

    function automatic logic [REG_W-1:0] pack_cmd(cmd_t c);
        logic [REG_W-1:0] w;
        w        = '0;
        w[C_RUN] = c.run;
        w[C_PER] = c.per_en;
        w[C_ASY] = c.asy_en;
        w[C_DB]  = c.doorbell;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] pack_sts(sts_t s);
        logic [REG_W-1:0] w;
        w        = '0;
        w[S_ASY] = s.asy_on;
        w[S_PER] = s.per_on;
        w[S_RCL] = s.reclaim;
        w[S_HLT] = s.halted;
        w[S_IAA] = s.iaa;
        return w;
    endfunction

    function automatic sel_e decode(logic [ADDR_W-1:0] a);
        if (a == CMD_OFS)      return SEL_CMD;
        else if (a == STS_OFS) return SEL_STS;
        else                   return SEL_NONE;
    endfunction

endpackage

// File: rtl/usbh_cmd_reg.sv
module usbh_cmd_reg
    import usbh_opreg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_cmd,
    input  logic wd_run,
    input  logic wd_per,
    input  logic wd_asy,
    input  logic wd_db,
    input  logic int_err,
    input  logic advance,
    output cmd_t cmd_q,
    output logic run_d,
    output logic adv_hit
);

    // Next run value: an internal error always wins over software
    always_comb begin
        if (int_err)     run_d = 1'b0;
        else if (wr_cmd) run_d = wd_run;
        else             run_d = cmd_q.run;
    end

    assign adv_hit = advance & cmd_q.doorbell;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else begin
            cmd_q.run <= run_d;
            if (wr_cmd) begin
                cmd_q.per_en <= wd_per;
                cmd_q.asy_en <= wd_asy;
            end
            // doorbell: a fresh write re-arms, an advance consumes
            if (wr_cmd && wd_db) cmd_q.doorbell <= 1'b1;
            else if (adv_hit)    cmd_q.doorbell <= 1'b0;
        end
    end

endmodule

// File: rtl/usbh_sched_track.sv
module usbh_sched_track (
    input  logic clk,
    input  logic rst,
    input  logic run_d,
    input  logic asy_en,
    input  logic per_en,
    input  logic asy_ack,
    input  logic per_ack,
    input  logic stopped,
    input  logic async_empty,
    output logic asy_on,
    output logic per_on,
    output logic halted,
    output logic reclaim
);

    always_ff @(posedge clk) begin
        if (rst) begin
            asy_on  <= 1'b0;
            per_on  <= 1'b0;
            halted  <= 1'b1;
            reclaim <= 1'b0;
        end else begin
            if (asy_ack) asy_on <= asy_en;
            if (per_ack) per_on <= per_en;
            if (run_d)        halted <= 1'b0;
            else if (stopped) halted <= 1'b1;
            reclaim <= async_empty;
        end
    end

endmodule

// File: rtl/usbh_w1c_flag.sv
module usbh_w1c_flag #(
    parameter int   WIDTH   = 1,
    parameter logic RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set,
    input  logic [WIDTH-1:0] clr,
    output logic [WIDTH-1:0] q
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)         q[i] <= RST_VAL;
            else if (set[i]) q[i] <= 1'b1;   // set beats clear
            else if (clr[i]) q[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/usbh_opreg_stat.sv
module usbh_opreg_stat
    import usbh_opreg_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     reg_addr,
    input  logic              reg_wen,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              eng_advance,
    input  logic              eng_stopped,
    input  logic              eng_int_err,
    input  logic              eng_async_ack,
    input  logic              eng_periodic_ack,
    input  logic              eng_async_empty,
    output logic              cmd_run,
    output logic              cmd_async_en,
    output logic              cmd_periodic_en,
    output logic              cmd_doorbell
);

    sel_e             sel;
    logic             wr_cmd, wr_sts;
    cmd_t             cmd_q;
    sts_t             sts;
    logic             run_d, adv_hit;
    logic [REG_W-1:0] sts_word, cmd_word;

    assign sel    = decode(ADDR_W'(reg_addr));
    assign wr_cmd = reg_wen && (sel == SEL_CMD);
    assign wr_sts = reg_wen && (sel == SEL_STS);

    usbh_cmd_reg u_cmd (
        .clk     (clk),
        .rst     (rst),
        .wr_cmd  (wr_cmd),
        .wd_run  (reg_wdata[C_RUN]),
        .wd_per  (reg_wdata[C_PER]),
        .wd_asy  (reg_wdata[C_ASY]),
        .wd_db   (reg_wdata[C_DB]),
        .int_err (eng_int_err),
        .advance (eng_advance),
        .cmd_q   (cmd_q),
        .run_d   (run_d),
        .adv_hit (adv_hit)
    );

    usbh_sched_track u_trk (
        .clk         (clk),
        .rst         (rst),
        .run_d       (run_d),
        .asy_en      (cmd_q.asy_en),
        .per_en      (cmd_q.per_en),
        .asy_ack     (eng_async_ack),
        .per_ack     (eng_periodic_ack),
        .stopped     (eng_stopped),
        .async_empty (eng_async_empty),
        .asy_on      (sts.asy_on),
        .per_on      (sts.per_on),
        .halted      (sts.halted),
        .reclaim     (sts.reclaim)
    );

    usbh_w1c_flag #(.WIDTH(1), .RST_VAL(1'b0)) u_iaa (
        .clk (clk),
        .rst (rst),
        .set (adv_hit),
        .clr (wr_sts && reg_wdata[S_IAA]),
        .q   (sts.iaa)
    );

    assign sts_word = pack_sts(sts);
    assign cmd_word = pack_cmd(cmd_q);

    always_comb begin
        unique case (sel)
            SEL_CMD: reg_rdata = cmd_word;
            SEL_STS: reg_rdata = sts_word;
            default: reg_rdata = '0;
        endcase
    end

    assign cmd_run         = cmd_q.run;
    assign cmd_async_en    = cmd_q.asy_en;
    assign cmd_periodic_en = cmd_q.per_en;
    assign cmd_doorbell    = cmd_q.doorbell;

endmodule

// File: rtl/usbh_opreg_chk.sv
module usbh_opreg_chk (
    input logic        clk,
    input logic        rst,
    input logic        eng_advance,
    input logic        eng_stopped,
    input logic        eng_int_err,
    input logic        eng_async_ack,
    input logic        eng_periodic_ack,
    input logic        eng_async_empty,
    input logic        cmd_run,
    input logic        cmd_doorbell,
    input logic [31:0] sts_word
);

    // R4
    a_r4_run_clears_halt: assert property (@(posedge clk) disable iff (rst)
        cmd_run |-> !sts_word[12]);

    // R3
    a_r3_async_hold: assert property (@(posedge clk) disable iff (rst)
        !eng_async_ack |=> $stable(sts_word[15]));

    // R3
    a_r3_periodic_hold: assert property (@(posedge clk) disable iff (rst)
        !eng_periodic_ack |=> $stable(sts_word[14]));

    // R5
    a_r5_halt_needs_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(sts_word[12]) |-> $past(eng_stopped));

    // R6
    a_r6_err_stops_run: assert property (@(posedge clk) disable iff (rst)
        eng_int_err |=> !cmd_run);

    // R8
    a_r8_iaa_needs_adv: assert property (@(posedge clk) disable iff (rst)
        $rose(sts_word[5]) |-> $past(eng_advance && cmd_doorbell));

    // R10
    a_r10_adv_sets_iaa: assert property (@(posedge clk) disable iff (rst)
        (eng_advance && cmd_doorbell) |=> sts_word[5]);

    // R11
    a_r11_reclaim_follows: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sts_word[13] == $past(eng_async_empty)));

endmodule

bind usbh_opreg_stat usbh_opreg_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .eng_advance      (eng_advance),
    .eng_stopped      (eng_stopped),
    .eng_int_err      (eng_int_err),
    .eng_async_ack    (eng_async_ack),
    .eng_periodic_ack (eng_periodic_ack),
    .eng_async_empty  (eng_async_empty),
    .cmd_run          (cmd_run),
    .cmd_doorbell     (cmd_doorbell),
    .sts_word         (sts_word)
);

// File: tb/usbh_opreg_stat_tb.sv
`timescale 1ns/1ps
module usbh_opreg_stat_tb;

    localparam logic [7:0] A_CMD = 8'h20;
    localparam logic [7:0] A_STS = 8'h24;
    localparam logic [7:0] A_BAD = 8'h28;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic eng_advance = 0, eng_stopped = 0, eng_int_err = 0;
    logic eng_async_ack = 0, eng_periodic_ack = 0, eng_async_empty = 0;
    logic cmd_run, cmd_async_en, cmd_periodic_en, cmd_doorbell;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference state
    bit m_run, m_per, m_asy, m_db, m_aon, m_pon, m_rcl, m_hlt, m_iaa;

    always #2.5 clk = ~clk;

    usbh_opreg_stat u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_advance(eng_advance), .eng_stopped(eng_stopped),
        .eng_int_err(eng_int_err), .eng_async_ack(eng_async_ack),
        .eng_periodic_ack(eng_periodic_ack), .eng_async_empty(eng_async_empty),
        .cmd_run(cmd_run), .cmd_async_en(cmd_async_en),
        .cmd_periodic_en(cmd_periodic_en), .cmd_doorbell(cmd_doorbell)
    );

    function automatic logic [31:0] exp_cmd();
        logic [31:0] w = '0;
        w[0] = m_run; w[4] = m_per; w[5] = m_asy; w[6] = m_db;
        return w;
    endfunction

    function automatic logic [31:0] exp_sts();
        logic [31:0] w = '0;
        w[15] = m_aon; w[14] = m_pon; w[13] = m_rcl; w[12] = m_hlt; w[5] = m_iaa;
        return w;
    endfunction

    task automatic model_reset();
        {m_run, m_per, m_asy, m_db, m_aon, m_pon, m_rcl, m_iaa} = '0;
        m_hlt = 1'b1;
    endtask

    task automatic chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        n_chk++;
        if (reg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic chk_both(input string tag);
        chk(tag, A_CMD, exp_cmd());
        chk(tag, A_STS, exp_sts());
    endtask

    // One clock: drive at the falling edge, advance the model at the rising edge
    task automatic step(input bit wen, input logic [7:0] a, input logic [31:0] wd,
                        input bit adv, input bit stp, input bit err,
                        input bit aack, input bit pack, input bit empty);
        bit wc, ws, hit, run_n;
        reg_wen = wen; reg_addr = a; reg_wdata = wd;
        eng_advance = adv; eng_stopped = stp; eng_int_err = err;
        eng_async_ack = aack; eng_periodic_ack = pack; eng_async_empty = empty;
        wc  = wen && (a == A_CMD);
        ws  = wen && (a == A_STS);
        hit = adv && m_db;
        run_n = err ? 1'b0 : (wc ? wd[0] : m_run);
        @(posedge clk);
        if (aack) m_aon = m_asy;
        if (pack) m_pon = m_per;
        m_hlt = run_n ? 1'b0 : (stp ? 1'b1 : m_hlt);
        m_rcl = empty;
        m_iaa = hit ? 1'b1 : ((ws && wd[5]) ? 1'b0 : m_iaa);
        m_db  = (wc && wd[6]) ? 1'b1 : (hit ? 1'b0 : m_db);
        if (wc) begin m_per = wd[4]; m_asy = wd[5]; end
        m_run = run_n;
        @(negedge clk);
        reg_wen = 0; eng_advance = 0; eng_stopped = 0; eng_int_err = 0;
        eng_async_ack = 0; eng_periodic_ack = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] wd);
        step(1, a, wd, 0, 0, 0, 0, 0, eng_async_empty);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish actual=timeout expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd24680));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset values
        chk("R1 status reset", A_STS, 32'h0000_1000);
        chk("R1 command reset", A_CMD, 32'h0);

        // R2 / R4: run set clears halted at the same edge
        wr(A_CMD, 32'h0000_0001);
        chk("R4 halted clears with run", A_STS, 32'h0);
        chk("R2 run readback", A_CMD, 32'h1);

        // R2: only bits 0,4,5 stick; bit 6 clear here
        wr(A_CMD, 32'hFFFF_FFB1);
        chk("R2 enables readback", A_CMD, 32'h0000_0031);

        // R3: no ack, no change; async ack then periodic ack
        chk("R3 status waits for ack", A_STS, 32'h0);
        step(0, A_STS, 0, 0, 0, 0, 1, 0, 0);
        chk("R3 async on after ack", A_STS, 32'h0000_8000);
        step(0, A_STS, 0, 0, 0, 0, 0, 1, 0);
        chk("R3 periodic on after ack", A_STS, 32'h0000_C000);

        // R5: stop while running is ignored
        step(0, A_STS, 0, 0, 1, 0, 0, 0, 0);
        chk("R5 stop ignored while running", A_STS, 32'h0000_C000);

        // R7 doorbell arm and write-zero no effect
        wr(A_CMD, 32'h0000_0071);
        chk("R7 doorbell pending", A_CMD, 32'h0000_0071);
        wr(A_CMD, 32'h0000_0031);
        chk("R7 write zero keeps doorbell", A_CMD, 32'h0000_0071);

        // R8 advance consumes doorbell and sets bit 5
        step(0, A_STS, 0, 1, 0, 0, 0, 0, 0);
        chk("R8 iaa set", A_STS, 32'h0000_C020);
        chk("R8 doorbell cleared", A_CMD, 32'h0000_0031);
        step(0, A_STS, 0, 1, 0, 0, 0, 0, 0);
        chk("R8 advance without doorbell", A_CMD, 32'h0000_0031);

        // R9 write-one-to-clear
        wr(A_STS, 32'h0);
        chk("R9 write zero keeps iaa", A_STS, 32'h0000_C020);
        wr(A_STS, 32'hFFFF_FFDF);
        chk("R9 read-only bits ignore writes", A_STS, 32'h0000_C020);
        wr(A_STS, 32'h0000_0020);
        chk("R9 iaa cleared", A_STS, 32'h0000_C000);

        // R10 set beats clear
        wr(A_CMD, 32'h0000_0071);
        step(1, A_STS, 32'h0000_0020, 1, 0, 0, 0, 0, 0);
        chk("R10 set wins over clear", A_STS, 32'h0000_C020);

        // R6 error beats software run write
        step(1, A_CMD, 32'h0000_0031, 0, 0, 1, 0, 0, 0);
        chk("R6 run dropped by error", A_CMD, 32'h0000_0030);
        chk("R5 halted waits for stop", A_STS, 32'h0000_C020);
        step(0, A_STS, 0, 0, 1, 0, 0, 0, 0);
        chk("R5 halted after stop", A_STS, 32'h0000_D020);

        // R11 reclamation
        step(0, A_STS, 0, 0, 0, 0, 0, 0, 1);
        chk("R11 reclaim set", A_STS, 32'h0000_F020);
        step(0, A_STS, 0, 0, 0, 0, 0, 0, 0);
        chk("R11 reclaim cleared", A_STS, 32'h0000_D020);

        // R12 unused offset
        wr(A_BAD, 32'hFFFF_FFFF);
        chk("R12 unused offset reads zero", A_BAD, 32'h0);
        chk_both("R12 unused write has no effect");

        // random phase against the reference model
        for (int i = 0; i < 3000; i++) begin
            int r = int'($urandom_range(0, 9));
            logic [7:0] a = (r < 4) ? A_CMD : (r < 7) ? A_STS : A_BAD;
            step($urandom_range(0, 1) == 1, a, $urandom(),
                 $urandom_range(0, 3) == 0, $urandom_range(0, 4) == 0,
                 $urandom_range(0, 19) == 0, $urandom_range(0, 3) == 0,
                 $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1);
            chk_both("R2-model random cycle");
            if (a == A_BAD) chk("R12 random unused read", A_BAD, 32'h0);
        end

        finish_run();
    end

endmodule